// File: doc/BRIEF.md
# Serial Receive Interrupt Register Block

This block sits between a serial deserialiser and the host bus. Each time the deserialiser hands over a complete character, the block stores it in a receive holding register and sets a data-ready flag. When receive interrupts are enabled, it raises an interrupt request toward the system interrupt controller.

The request remembers the character that caused it. It stays asserted until the host reads the holding register, and that read is the only thing that completes it. An enable register holds four interrupt-source enable bits. Only bit 0, the receive enable, affects logic here; the other three bits are stored and read back for sources that live elsewhere.

A status register reports data-ready and overrun. An overrun is a character that arrives while the previous one is still unread.

Top module: `uart_rx_irq`

## Requirements
- R1: After reset `irq` is 0, and the enable, status and holding registers all read 0.
- R2: A write to offset 1 stores `bus_wdata[3:0]` as the enable bits. A read of offset 1 returns them in bits 3:0, with bits 7:4 reading 0.
- R3: A cycle with `rx_valid` high loads `rx_byte` into the holding register and sets data-ready (status bit 0). If enable bit 0 is set, `irq` is high from the next cycle.
- R4: `irq` stays high until the host reads offset 0. That read returns the held byte and clears data-ready, and `irq` is low from the next cycle.
- R5: Enable bits 1, 2 and 3 never raise `irq`, whatever the data-ready state.
- R6: A character that arrives while data-ready is set, with no read of offset 0 in the same cycle, replaces the held byte and sets overrun (status bit 1). `irq` stays high.
- R7: A read of offset 5 returns {6'b0, overrun, data-ready} and then clears overrun. Data-ready is unchanged.
- R8: Writing enable bit 0 as 0 while data-ready is set drops `irq` from the next cycle and keeps data-ready. Writing it back to 1 raises `irq` again.
- R9: A character that arrives in the same cycle as a read of offset 0 is kept. Data-ready stays set and overrun is not set.
- R10: With enable bit 0 clear, a received character sets data-ready but leaves `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a complete character is present |
| rx_byte | input | 8 | Received character |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe (side effects on this cycle) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current register state |
| irq | output | 1 | Interrupt request to the controller |

## Verification
The receive path is tried four ways:
- A single character with the receive enable set shows that the request is raised and then completed by the data read.
- The same character with the enable clear, or with only the other enable bits set, shows that the request depends on bit 0 alone.
- Two characters back to back without a read show overwrite and overrun.
- A character that lands in the same cycle as a data read shows that this case is kept apart from an overrun.

Toggling the enable while a character is pending shows that masking hides the request without losing the data.

// File: rtl/uart_rx_irq.sv
module uart_rx_irq #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int SRC_N    = 4,
  parameter int OFS_DATA = 0,
  parameter int OFS_IEN  = 1,
  parameter int OFS_STAT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] hold_q;
  logic [SRC_N-1:0]  ien_q;
  logic              ready_q;
  logic              ovr_q;

  wire rd_data = bus_rd && (bus_addr == ADDR_W'(OFS_DATA));
  wire rd_stat = bus_rd && (bus_addr == ADDR_W'(OFS_STAT));
  wire wr_ien  = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
  wire ovr_hit = rx_valid && ready_q && !rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      ien_q   <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (wr_ien) ien_q <= bus_wdata[SRC_N-1:0];
      if (rx_valid) begin
        hold_q  <= rx_byte;
        ready_q <= 1'b1;
      end else if (rd_data) begin
        ready_q <= 1'b0;
      end
      if (ovr_hit)      ovr_q <= 1'b1;
      else if (rd_stat) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_DATA))      bus_rdata = hold_q;
    else if (bus_addr == ADDR_W'(OFS_IEN))  bus_rdata[SRC_N-1:0] = ien_q;
    else if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata[1:0] = {ovr_q, ready_q};
  end

  assign irq = ien_q[0] && ready_q;
endmodule

module uart_rx_irq_chk #(
  parameter int ADDR_W = 3,
  parameter int SRC_N  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [SRC_N-1:0]  ien_q,
  input logic              ready_q,
  input logic              ovr_q,
  input logic              irq
);
  // R2
  ien_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1)) |=> (ien_q == $past(bus_wdata[SRC_N-1:0])));
  // R3
  rx_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> ready_q);
  // R4
  data_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(0) && !rx_valid) |=> (!ready_q && !irq));
  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && ready_q && !(bus_rd && bus_addr == ADDR_W'(0))) |=> ovr_q);
  // R7
  stat_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(5) && !rx_valid) |=> !ovr_q);
  // R8
  mask_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1) && !bus_wdata[0]) |=> !irq);
endmodule

bind uart_rx_irq uart_rx_irq_chk #(.ADDR_W(ADDR_W), .SRC_N(SRC_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .bus_addr(bus_addr),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .ien_q(ien_q), .ready_q(ready_q), .ovr_q(ovr_q), .irq(irq));

// File: tb/uart_rx_irq_tb.sv
`timescale 1ns/1ps
module uart_rx_irq_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic [2:0] bus_addr = 0;
  logic       bus_rd = 0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_rx_irq dut_i (.clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    check("R1 irq", {7'b0, irq}, 8'h00);
    bus_read(1, d); check("R1 ien", d, 8'h00);
    bus_read(5, d); check("R1 status", d, 8'h00);
    bus_read(0, d); check("R1 data", d, 8'h00);
  endtask

  task automatic t_ien_rw();
    logic [7:0] d;
    do_reset();
    bus_write(1, 8'hFA); bus_read(1, d); check("R2 ien readback", d, 8'h0A);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    do_reset();
    bus_write(1, 8'h01);
    rx_push(8'h5C);
    check("R3 irq raised", {7'b0, irq}, 8'h01);
    bus_read(5, d); check("R3 ready", d, 8'h01);
    repeat (4) @(negedge clk);
    check("R4 irq held", {7'b0, irq}, 8'h01);
    bus_read(0, d); check("R4 data", d, 8'h5C);
    check("R4 irq dropped", {7'b0, irq}, 8'h00);
    bus_read(5, d); check("R4 ready cleared", d, 8'h00);
  endtask

  task automatic t_other_src();
    logic [7:0] d;
    do_reset();
    bus_write(1, 8'h0E);
    rx_push(8'h11);
    check("R5 no irq", {7'b0, irq}, 8'h00);
    bus_read(5, d); check("R5 ready", d, 8'h01);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    do_reset();
    rx_push(8'h22);
    check("R10 no irq", {7'b0, irq}, 8'h00);
    bus_read(5, d); check("R10 ready", d, 8'h01);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    do_reset();
    bus_write(1, 8'h01);
    rx_push(8'hA1); rx_push(8'hB2);
    check("R6 irq stays", {7'b0, irq}, 8'h01);
    bus_read(5, d); check("R6 status", d, 8'h03);
    bus_read(5, d); check("R7 overrun cleared", d, 8'h01);
    bus_read(0, d); check("R6 newest byte", d, 8'hB2);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    do_reset();
    bus_write(1, 8'h01);
    rx_push(8'h77);
    bus_write(1, 8'h00);
    check("R8 irq masked", {7'b0, irq}, 8'h00);
    bus_read(5, d); check("R8 ready kept", d, 8'h01);
    bus_write(1, 8'h01);
    check("R8 irq re-raised", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    do_reset();
    bus_write(1, 8'h01);
    rx_push(8'h31);
    @(negedge clk); bus_rd = 1; bus_addr = 0; rx_valid = 1; rx_byte = 8'h42;
    #1 d = bus_rdata; check("R9 old byte read", d, 8'h31);
    @(negedge clk); bus_rd = 0; rx_valid = 0;
    check("R9 irq", {7'b0, irq}, 8'h01);
    bus_read(5, d); check("R9 status", d, 8'h01);
    bus_read(0, d); check("R9 new byte", d, 8'h42);
  endtask

  initial begin
    t_reset(); t_ien_rw(); t_basic(); t_other_src(); t_disabled();
    t_overrun(); t_mask(); t_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule